// File: doc/BRIEF.md
# NAND ECC Page Geometry Calculator

This block turns a flash page size and a spare-area size, both in bytes, into the settings that a BCH-style correction engine needs for that page. From one request it selects the chunk format, counts the chunks, works out the strongest even correction level that the spare area can hold, and finds where the factory bad-block marker ends up. The correction engine interleaves each chunk's parity bits with the data, so the marker byte is displaced from its linear position. The block gives that displaced position as a byte offset and a bit offset within the data buffer. It also gives the packed fields that a layout register of the correction engine expects.

A request is a single-cycle `start` pulse while the block is idle. The page and spare sizes are captured on that edge. Every division runs on one restoring shift-subtract divider that produces one quotient bit per clock. A controller in the state machine feeds it three problems in turn: the chunk count, then the strength, then the marker chunk. The states are IDLE (waiting), CHECK (geometry screen and chunk-count division launch), WAIT_CNT, LOAD_STR, WAIT_STR, LOAD_MARK, WAIT_MARK and FINISH.

The transitions are as follows:
- IDLE goes to CHECK on `start`.
- CHECK goes to FINISH on an unsupported geometry, and otherwise to WAIT_CNT.
- WAIT_CNT goes to LOAD_STR when the divider finishes.
- LOAD_STR goes to FINISH on a zero chunk count, and otherwise to WAIT_STR.
- WAIT_STR goes to LOAD_MARK when the divider finishes.
- LOAD_MARK goes to WAIT_MARK unconditionally.
- WAIT_MARK goes to FINISH when the divider finishes.
- FINISH goes back to IDLE after one cycle.

Top module: `nand_geom_calc`

## Requirements
- R1: After reset, `busy`, `done` and `err` are 0 and every result and layout output is 0.
- R2: A spare size above 512 bytes selects 1024-byte chunks with 14 parity bits per correction level, and sets `lay_gf14` to 1 and `lay_csize` to 1024>>CSIZE_SHIFT. Any other spare size selects 512-byte chunks with 13 bits per level, `lay_gf14` = 0 and `lay_csize` = 512>>CSIZE_SHIFT.
- R3: A spare size of 10 bytes or less, or a spare size larger than the selected chunk size, ends the request with `err` = 1. In that case strength, chunk count, marker offsets and all layout fields are 0.
- R4: `chunks` equals the page size divided by the chunk size, rounded down. A result of 0 ends the request with `err` = 1 and all outputs are 0.
- R5: `strength` is ((spare − 10) × 8) / (bits-per-level × chunks), rounded down, then rounded down to an even value and capped at MAX_STRENGTH (40 by default).
- R6: Let B = page × 8 − 80. Divide B by (chunk bytes × 8 + strength × bits-per-level) to get a quotient q and a remainder r. If r exceeds chunk bytes × 8, the marker bit position is 1. Otherwise it is B − q × strength × bits-per-level.
- R7: `mark_byte` is the marker bit position shifted right by 3, and `mark_bit` is its low 3 bits.
- R8: On success the layout fields are: `lay_nblk` = chunks − 1, `lay_meta` = 10, `lay_ecc` = strength / 2, plus the chunk-size code and mode flag of R2.
- R9: `done` is high for exactly one cycle at the end of every accepted request, with `busy` high from the cycle after `start` through that cycle. All results stay unchanged until the next accepted `start`, even if the size inputs change.
- R10: A `start` pulse while `busy` is high is ignored. The running request finishes with results from its own captured sizes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, accepted only while idle |
| page_bytes | input | PW | Page data size in bytes |
| spare_bytes | input | PW | Spare area size in bytes |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Unsupported geometry |
| strength | output | SW | Correction level per chunk |
| chunks | output | CW | Number of chunks per page |
| mark_byte | output | PW | Marker byte offset in data buffer |
| mark_bit | output | 3 | Marker bit offset within that byte |
| lay_nblk | output | CW | Chunk count minus one |
| lay_meta | output | 8 | Metadata size field |
| lay_ecc | output | SW | Strength divided by two |
| lay_csize | output | PW | Chunk size code |
| lay_gf14 | output | 1 | 14-bit parity field mode flag |

## Verification
A wrong state in the divider shows up as a wrong `chunks` or `strength` on the `done` cycle. A chunk count that is off by one also moves the marker position by a whole chunk's worth of parity bits, so a single fault is visible in several outputs. A stuck or skipped controller state shows as `done` arriving with stale or zero results, or as `done` never rising, which the bench flags within about one thousand cycles. The geometry cases are chosen to hit the strength cap, the 14-bit mode, a non-zero bit offset and the branch that forces the position to 1, so a broken branch changes a port value directly.

// File: rtl/nand_geom_pkg.sv
package nand_geom_pkg;
    localparam int META_BYTES  = 10;
    localparam int SMALL_CHUNK = 512;
    localparam int LARGE_CHUNK = 1024;
    localparam int PAR_NARROW  = 13;
    localparam int PAR_WIDE    = 14;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_WAIT_CNT,
        ST_LOAD_STR,
        ST_WAIT_STR,
        ST_LOAD_MARK,
        ST_WAIT_MARK,
        ST_FINISH
    } geom_state_e;
endpackage

// File: rtl/geom_mode.sv
module geom_mode
    import nand_geom_pkg::*;
#(
    parameter int PW = 16
) (
    input  logic [PW-1:0] spare,
    output logic          gf14,
    output logic [PW-1:0] csize,
    output logic [3:0]    bpl,
    output logic          bad
);
    always_comb begin
        gf14  = (spare > PW'(SMALL_CHUNK));
        csize = gf14 ? PW'(LARGE_CHUNK) : PW'(SMALL_CHUNK);
        bpl   = gf14 ? 4'(PAR_WIDE) : 4'(PAR_NARROW);
        bad   = (spare > csize) || (spare <= PW'(META_BYTES));
    end
endmodule

// File: rtl/geom_div.sv
module geom_div #(
    parameter int DW = 19
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [DW-1:0] num,
    input  logic [DW-1:0] den,
    output logic          fin,
    output logic [DW-1:0] quo,
    output logic [DW-1:0] rem
);
    localparam int CNTW = $clog2(DW + 1);

    logic [CNTW-1:0] cnt_q;
    logic            run_q;
    logic [DW-1:0]   den_q;
    logic [DW:0]     trial;

    // partial remainder shifted left by one with the next dividend bit
    assign trial = {rem, quo[DW-1]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
            fin   <= 1'b0;
            quo   <= '0;
            rem   <= '0;
            den_q <= '0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                quo   <= num;
                rem   <= '0;
                den_q <= den;
                cnt_q <= CNTW'(DW);
                run_q <= 1'b1;
            end else if (run_q) begin
                if (trial >= {1'b0, den_q}) begin
                    rem <= DW'(trial - {1'b0, den_q});
                    quo <= {quo[DW-2:0], 1'b1};
                end else begin
                    rem <= trial[DW-1:0];
                    quo <= {quo[DW-2:0], 1'b0};
                end
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNTW'(1)) begin
                    run_q <= 1'b0;
                    fin   <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/geom_pack.sv
module geom_pack
    import nand_geom_pkg::*;
#(
    parameter int PW          = 16,
    parameter int CW          = 8,
    parameter int SW          = 8,
    parameter int CSIZE_SHIFT = 2
) (
    input  logic          valid,
    input  logic [CW-1:0] chunks,
    input  logic [SW-1:0] strength,
    input  logic          gf14,
    input  logic [PW-1:0] csize,
    output logic [CW-1:0] lay_nblk,
    output logic [7:0]    lay_meta,
    output logic [SW-1:0] lay_ecc,
    output logic [PW-1:0] lay_csize,
    output logic          lay_gf14
);
    always_comb begin
        lay_nblk  = valid ? (chunks - 1'b1) : '0;
        lay_meta  = valid ? 8'(META_BYTES) : '0;
        lay_ecc   = valid ? (strength >> 1) : '0;
        lay_csize = valid ? (csize >> CSIZE_SHIFT) : '0;
        lay_gf14  = valid & gf14;
    end
endmodule

// File: rtl/nand_geom_calc.sv
module nand_geom_calc
    import nand_geom_pkg::*;
#(
    parameter int PW           = 16,
    parameter int CW           = 8,
    parameter int SW           = 8,
    parameter int MAX_STRENGTH = 40,
    parameter int CSIZE_SHIFT  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [PW-1:0] page_bytes,
    input  logic [PW-1:0] spare_bytes,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [SW-1:0] strength,
    output logic [CW-1:0] chunks,
    output logic [PW-1:0] mark_byte,
    output logic [2:0]    mark_bit,
    output logic [CW-1:0] lay_nblk,
    output logic [7:0]    lay_meta,
    output logic [SW-1:0] lay_ecc,
    output logic [PW-1:0] lay_csize,
    output logic          lay_gf14
);
    localparam int DW = PW + 3;

    geom_state_e st_q, st_d;

    logic [PW-1:0] pg_q, sp_q;
    logic [CW-1:0] chunks_q;
    logic [SW-1:0] str_q;
    logic [DW-1:0] off_q;
    logic          err_q, ok_q;

    logic          gf14, bad;
    logic [PW-1:0] csize;
    logic [3:0]    bpl;

    logic          div_go, div_fin;
    logic [DW-1:0] div_num, div_den, div_quo, div_rem;

    logic [DW-1:0] mark_base, chunk_bits, par_bits, even_q, mark_red;
    logic [SW-1:0] str_cap;
    logic          forced;

    geom_mode #(.PW(PW)) mode_i (
        .spare (sp_q),
        .gf14  (gf14),
        .csize (csize),
        .bpl   (bpl),
        .bad   (bad)
    );

    geom_div #(.DW(DW)) div_i (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (div_go),
        .num   (div_num),
        .den   (div_den),
        .fin   (div_fin),
        .quo   (div_quo),
        .rem   (div_rem)
    );

    geom_pack #(.PW(PW), .CW(CW), .SW(SW), .CSIZE_SHIFT(CSIZE_SHIFT)) pack_i (
        .valid     (ok_q),
        .chunks    (chunks_q),
        .strength  (str_q),
        .gf14      (gf14),
        .csize     (csize),
        .lay_nblk  (lay_nblk),
        .lay_meta  (lay_meta),
        .lay_ecc   (lay_ecc),
        .lay_csize (lay_csize),
        .lay_gf14  (lay_gf14)
    );

    // arithmetic shared by the operand mux and the result capture
    always_comb begin
        mark_base  = (DW'(pg_q) << 3) - DW'(META_BYTES * 8);
        chunk_bits = DW'(csize) << 3;
        par_bits   = DW'(str_q) * DW'(bpl);
        even_q     = {div_quo[DW-1:1], 1'b0};
        str_cap    = (even_q > DW'(MAX_STRENGTH)) ? SW'(MAX_STRENGTH) : SW'(even_q);
        forced     = (div_rem > chunk_bits);
        mark_red   = mark_base - div_quo * par_bits;
    end

    // divider operand selection per launching state
    always_comb begin
        div_go  = 1'b0;
        div_num = '0;
        div_den = '0;
        unique case (st_q)
            ST_CHECK: begin
                div_go  = !bad;
                div_num = DW'(pg_q);
                div_den = DW'(csize);
            end
            ST_LOAD_STR: begin
                div_go  = (chunks_q != '0);
                div_num = DW'(sp_q - PW'(META_BYTES)) << 3;
                div_den = DW'(bpl) * DW'(chunks_q);
            end
            ST_LOAD_MARK: begin
                div_go  = 1'b1;
                div_num = mark_base;
                div_den = chunk_bits + par_bits;
            end
            default: ;
        endcase
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:      if (start) st_d = ST_CHECK;
            ST_CHECK:     st_d = bad ? ST_FINISH : ST_WAIT_CNT;
            ST_WAIT_CNT:  if (div_fin) st_d = ST_LOAD_STR;
            ST_LOAD_STR:  st_d = (chunks_q == '0) ? ST_FINISH : ST_WAIT_STR;
            ST_WAIT_STR:  if (div_fin) st_d = ST_LOAD_MARK;
            ST_LOAD_MARK: st_d = ST_WAIT_MARK;
            ST_WAIT_MARK: if (div_fin) st_d = ST_FINISH;
            ST_FINISH:    st_d = ST_IDLE;
            default:      st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pg_q     <= '0;
            sp_q     <= '0;
            chunks_q <= '0;
            str_q    <= '0;
            off_q    <= '0;
            err_q    <= 1'b0;
            ok_q     <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (start) begin
                    pg_q     <= page_bytes;
                    sp_q     <= spare_bytes;
                    chunks_q <= '0;
                    str_q    <= '0;
                    off_q    <= '0;
                    err_q    <= 1'b0;
                    ok_q     <= 1'b0;
                end
                ST_CHECK:     if (bad) err_q <= 1'b1;
                ST_WAIT_CNT:  if (div_fin) chunks_q <= CW'(div_quo);
                ST_LOAD_STR:  if (chunks_q == '0) err_q <= 1'b1;
                ST_WAIT_STR:  if (div_fin) str_q <= str_cap;
                ST_WAIT_MARK: if (div_fin) begin
                    off_q <= forced ? DW'(1) : mark_red;
                    ok_q  <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign busy      = (st_q != ST_IDLE);
    assign done      = (st_q == ST_FINISH);
    assign err       = err_q;
    assign strength  = str_q;
    assign chunks    = chunks_q;
    assign mark_byte = off_q[DW-1:3];
    assign mark_bit  = off_q[2:0];
endmodule

// File: rtl/geom_chk.sv
module geom_chk #(
    parameter int PW           = 16,
    parameter int CW           = 8,
    parameter int SW           = 8,
    parameter int MAX_STRENGTH = 40
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          err,
    input logic [SW-1:0] strength,
    input logic [CW-1:0] chunks,
    input logic [PW-1:0] mark_byte,
    input logic [CW-1:0] lay_nblk
);
    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R10
    busy_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(strength) && $stable(chunks) && $stable(mark_byte) && $stable(err)));

    // R5
    strength_even_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (!strength[0] && (strength <= SW'(MAX_STRENGTH))));

    // R3
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (strength == '0 && chunks == '0 && mark_byte == '0));

    // R4
    chunks_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (chunks != '0));

    // R8
    nblk_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (lay_nblk == chunks - 1'b1));
endmodule

bind nand_geom_calc geom_chk #(
    .PW(PW), .CW(CW), .SW(SW), .MAX_STRENGTH(MAX_STRENGTH)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .strength  (strength),
    .chunks    (chunks),
    .mark_byte (mark_byte),
    .lay_nblk  (lay_nblk)
);

// File: tb/nand_geom_calc_tb.sv
`timescale 1ns/1ps
module nand_geom_calc_tb_top;
    localparam int PW = 16, CW = 8, SW = 8, MAXS = 40, SHIFT = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [PW-1:0] page_bytes = '0, spare_bytes = '0;
    logic          busy, done, err, lay_gf14;
    logic [SW-1:0] strength, lay_ecc;
    logic [CW-1:0] chunks, lay_nblk;
    logic [PW-1:0] mark_byte, lay_csize;
    logic [2:0]    mark_bit;
    logic [7:0]    lay_meta;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    nand_geom_calc #(.PW(PW), .CW(CW), .SW(SW), .MAX_STRENGTH(MAXS), .CSIZE_SHIFT(SHIFT)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .page_bytes(page_bytes),
        .spare_bytes(spare_bytes), .busy(busy), .done(done), .err(err),
        .strength(strength), .chunks(chunks), .mark_byte(mark_byte),
        .mark_bit(mark_bit), .lay_nblk(lay_nblk), .lay_meta(lay_meta),
        .lay_ecc(lay_ecc), .lay_csize(lay_csize), .lay_gf14(lay_gf14)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // expected results from the requirement formulas
    task automatic model(input int page, input int spare, output int e_err, output int e_str,
                         output int e_cnt, output int e_off, output int e_gf, output int e_cs);
        int bpl, base, den, q, r;
        e_gf = (spare > 512) ? 1 : 0;
        e_cs = e_gf ? 1024 : 512;
        bpl  = e_gf ? 14 : 13;
        e_err = 0; e_str = 0; e_cnt = 0; e_off = 0;
        if (spare <= 10 || spare > e_cs) begin
            e_err = 1;
            return;
        end
        e_cnt = page / e_cs;
        if (e_cnt == 0) begin
            e_err = 1;
            return;
        end
        e_str = ((spare - 10) * 8) / (bpl * e_cnt);
        e_str = e_str - (e_str % 2);
        if (e_str > MAXS) e_str = MAXS;
        base = page * 8 - 80;
        den  = e_cs * 8 + e_str * bpl;
        q = base / den;
        r = base - q * den;
        e_off = (r > e_cs * 8) ? 1 : base - q * e_str * bpl;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 1000) begin
            @(negedge clk);
            n++;
        end
        check({"R9 done seen ", tag}, int'(done), 1);
    endtask

    task automatic check_results(input string tag, input int page, input int spare);
        int e_err, e_str, e_cnt, e_off, e_gf, e_cs, ok;
        model(page, spare, e_err, e_str, e_cnt, e_off, e_gf, e_cs);
        ok = 1 - e_err;
        check({"R3 err ", tag}, int'(err), e_err);
        check({"R4 chunks ", tag}, int'(chunks), e_cnt);
        check({"R5 strength ", tag}, int'(strength), e_str);
        check({"R6 R7 mark_byte ", tag}, int'(mark_byte), e_off / 8);
        check({"R6 R7 mark_bit ", tag}, int'(mark_bit), e_off % 8);
        check({"R2 lay_gf14 ", tag}, int'(lay_gf14), ok * e_gf);
        check({"R2 lay_csize ", tag}, int'(lay_csize), ok * (e_cs >> SHIFT));
        check({"R8 lay_nblk ", tag}, int'(lay_nblk), ok * (e_cnt - 1));
        check({"R8 lay_meta ", tag}, int'(lay_meta), ok * 10);
        check({"R8 lay_ecc ", tag}, int'(lay_ecc), ok * (e_str / 2));
    endtask

    task automatic run_case(input string tag, input int page, input int spare);
        @(negedge clk);
        page_bytes = PW'(page); spare_bytes = PW'(spare); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({"R9 busy after start ", tag}, int'(busy), 1);
        wait_done(tag);
        check_results(tag, page, spare);
        @(negedge clk);
        check({"R9 done one cycle ", tag}, int'(done), 0);
    endtask

    task automatic test_reset();
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 err", int'(err), 0);
        check("R1 strength", int'(strength), 0);
        check("R1 chunks", int'(chunks), 0);
        check("R1 mark_byte", int'(mark_byte), 0);
        check("R1 lay_meta", int'(lay_meta), 0);
        check("R1 lay_nblk", int'(lay_nblk), 0);
    endtask

    task automatic test_busy_ignore();
        @(negedge clk);
        page_bytes = 16'd2048; spare_bytes = 16'd64; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        page_bytes = 16'd8192; spare_bytes = 16'd640; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R10 busy start");
        check_results("R10 ignored start", 2048, 64);
        @(negedge clk);
    endtask

    task automatic test_hold();
        run_case("R9 hold base", 4096, 224);
        page_bytes = 16'd512; spare_bytes = 16'd16;
        repeat (6) @(negedge clk);
        check("R9 idle busy", int'(busy), 0);
        check_results("R9 held", 4096, 224);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        run_case("R5 R6 2048/64", 2048, 64);
        run_case("R6 R7 bit 2048/112", 2048, 112);
        run_case("R5 4096/128", 4096, 128);
        run_case("R2 R5 cap 8192/640", 8192, 640);
        run_case("R6 forced 523/16", 523, 16);
        run_case("R3 spare 10", 2048, 10);
        run_case("R3 spare too big", 8192, 1100);
        run_case("R4 zero chunks", 256, 64);
        run_case("R2 edge 2048/512", 2048, 512);
        test_busy_ignore();
        test_hold();
        finish_run();
    end
endmodule